// File: doc/BRIEF.md
# Indexed-Mode Bus Cycle Sequencer

This block drives the external bus of an 8-bit processor while it runs an instruction in indexed addressing mode. In this mode the effective address (EA) is the X index register plus an unsigned 8-bit offset. The offset is the byte that follows the opcode in the instruction stream. On a start pulse the block captures the program counter, X, the stack pointer and an instruction class. From then on it gives one bus cycle per clock: an address, a read/write level and, on write cycles, a data byte. The sequence covers the opcode fetch, the offset fetch, the dead cycles, the operand transfers and the writes, and each class takes its own exact number of cycles.

An optional page-select prefix byte adds one opcode fetch cycle and moves every later instruction-stream byte up by one address. The block does not compute results, update flags or decide branches. Store data and read-modify-write results come in on `reg_data`, and the block places them on the bus in the write cycle. A one-cycle `done` marks the final bus cycle and presents the next program counter and stack pointer.

Top module: `idx_bus_seq`

## Requirements
- R1: Every sequence begins with a read at PC (the opcode). The offset read follows at the next instruction-stream address, then a dummy read at address 0xFFFF.
- R2: With `prefix` = 1 a second opcode read at PC+1 is inserted. The offset then comes from PC+2 and the sequence is one cycle longer.
- R3: Class 0 (16-bit load) reads EA and then EA+1 after the dummy cycle. It lasts 5 cycles, or 6 with the prefix.
- R4: Class 1 (16-bit store) ends with two write cycles: `reg_data[15:8]` to EA, then `reg_data[7:0]` to EA+1. It lasts 5 cycles, or 6 with the prefix.
- R5: Class 2 (16-bit add/subtract/compare) reads EA and EA+1, then ends with a dummy read at 0xFFFF. It lasts 6 cycles, or 7 with the prefix.
- R6: Class 3 (indexed call) reads EA, writes the return address low byte at SP, then writes the high byte at SP-1. The return address is the address after the instruction. At completion `pc_out` = EA and `sp_out` = SP-2.
- R7: Class 4 (bit set/clear) runs: opcode, offset, dummy, read EA, mask read at the next stream address, dummy, write of `reg_data[7:0]` to EA. That is 7 cycles.
- R8: Class 5 (bit test and branch) runs: opcode, offset, dummy, read EA, mask read, branch-offset read, dummy. That is 7 cycles, with no write cycle.
- R9: EA = X + zero-extended offset, modulo 2^16. EA+1 also wraps from 0xFFFF to 0x0000.
- R10: `done` is high for exactly the final bus cycle. Except for the call, `pc_out` then equals the address after the last instruction-stream byte, and `sp_out` equals the captured SP.
- R11: A `start` that arrives while a sequence is active has no effect on the running sequence.
- R12: `rw` is 1 (read) on every cycle that is not a write, including dummy and idle cycles. Idle shows address 0xFFFF, and `dout` is 0 on reads. Class codes 6 and 7 behave as class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| iclass | input | 3 | Instruction class code |
| prefix | input | 1 | Page-select prefix byte present |
| pc_in | input | 16 | Program counter at the opcode |
| x_in | input | 16 | X index register |
| sp_in | input | 16 | Stack pointer |
| reg_data | input | 16 | Store data / result byte source |
| din | input | 8 | Bus read data |
| addr | output | 16 | Bus address |
| rw | output | 1 | 1 = read, 0 = write |
| dout | output | 8 | Bus write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final bus cycle of the sequence |
| pc_out | output | 16 | Next program counter, valid with done |
| sp_out | output | 16 | Next stack pointer, valid with done |

## Verification
The hardest case to reach is a second `start` landing in the middle of a running sequence, carrying different class, PC and X values. The stimulus pulses `start` again in the second cycle of a prefixed arithmetic sequence. The scoreboard then expects the original 7-cycle sequence, unchanged. Effective-address wrap is reached by choosing X = 0xFFF0 with offset 0x0F, so that EA is 0xFFFF and EA+1 rolls over to 0x0000. Prefixed and unprefixed variants, plus a PC near the top of memory, exercise how the instruction-stream cursor moves.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int STEP_W = 3;

    typedef enum logic [2:0] {
        CL_LOAD   = 3'd0,
        CL_STORE  = 3'd1,
        CL_ARITH  = 3'd2,
        CL_CALL   = 3'd3,
        CL_BITMOD = 3'd4,
        CL_BITBR  = 3'd5
    } cls_e;

    typedef enum logic [3:0] {
        K_PROG,
        K_OFF,
        K_DUM,
        K_RD_EA,
        K_RD_EA1,
        K_WR_EA_HI,
        K_WR_EA1_LO,
        K_WR_SP,
        K_WR_SP1,
        K_WR_EA
    } kind_e;

    typedef struct packed {
        logic              busy;
        logic [STEP_W-1:0] step;
        cls_e              cls;
        logic              pfx;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] x;
        logic [ADDR_W-1:0] sp;
        logic [DATA_W-1:0] off;
    } seq_st_t;
endpackage

// File: rtl/idx_step_decode.sv
module idx_step_decode
    import idx_seq_pkg::*;
#(
    parameter int SW = STEP_W
) (
    input  cls_e          cls,
    input  logic          pfx,
    input  logic [SW-1:0] step,
    output kind_e         kind,
    output logic          last
);
    localparam int LW = SW + 1;

    logic [SW-1:0] s;
    logic          pfx_slot;
    logic [LW-1:0] base_len;

    always_comb begin
        s        = step;
        pfx_slot = 1'b0;
        if (pfx) begin
            if (step == SW'(1)) pfx_slot = 1'b1;
            else if (step > SW'(1)) s = step - SW'(1);
        end

        case (cls)
            CL_LOAD, CL_STORE:  base_len = LW'(5);
            CL_ARITH, CL_CALL:  base_len = LW'(6);
            default:            base_len = LW'(7);
        endcase
        last = ({1'b0, step} == (base_len + LW'(pfx) - LW'(1)));

        kind = K_DUM;
        if (pfx_slot) begin
            kind = K_PROG;
        end else begin
            case (s)
                SW'(0): kind = K_PROG;
                SW'(1): kind = K_OFF;
                SW'(2): kind = K_DUM;
                SW'(3): kind = (cls == CL_STORE) ? K_WR_EA_HI : K_RD_EA;
                SW'(4): begin
                    case (cls)
                        CL_STORE:              kind = K_WR_EA1_LO;
                        CL_CALL:               kind = K_WR_SP;
                        CL_BITMOD, CL_BITBR:   kind = K_PROG;
                        default:               kind = K_RD_EA1;
                    endcase
                end
                SW'(5): begin
                    case (cls)
                        CL_CALL:  kind = K_WR_SP1;
                        CL_BITBR: kind = K_PROG;
                        default:  kind = K_DUM;
                    endcase
                end
                SW'(6): kind = (cls == CL_BITMOD) ? K_WR_EA : K_DUM;
                default: kind = K_DUM;
            endcase
        end
    end
endmodule

// File: rtl/idx_addr_mux.sv
module idx_addr_mux
    import idx_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          active,
    input  kind_e         kind,
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] x,
    input  logic [DW-1:0] off,
    input  logic [AW-1:0] sp,
    input  logic [2*DW-1:0] reg_data,
    output logic [AW-1:0] ea,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] dout
);
    localparam logic [AW-1:0] DUMMY_ADDR = '1;

    logic [AW-1:0] ea1;

    assign ea  = x + {{(AW-DW){1'b0}}, off};
    assign ea1 = ea + AW'(1);

    always_comb begin
        addr = DUMMY_ADDR;
        rw   = 1'b1;
        dout = '0;
        if (active) begin
            case (kind)
                K_PROG, K_OFF: addr = cur;
                K_DUM:         addr = DUMMY_ADDR;
                K_RD_EA:       addr = ea;
                K_RD_EA1:      addr = ea1;
                K_WR_EA_HI: begin
                    addr = ea;
                    rw   = 1'b0;
                    dout = reg_data[2*DW-1:DW];
                end
                K_WR_EA1_LO: begin
                    addr = ea1;
                    rw   = 1'b0;
                    dout = reg_data[DW-1:0];
                end
                K_WR_EA: begin
                    addr = ea;
                    rw   = 1'b0;
                    dout = reg_data[DW-1:0];
                end
                K_WR_SP: begin
                    addr = sp;
                    rw   = 1'b0;
                    dout = cur[DW-1:0];
                end
                K_WR_SP1: begin
                    addr = sp - AW'(1);
                    rw   = 1'b0;
                    dout = cur[AW-1:AW-DW];
                end
                default: addr = DUMMY_ADDR;
            endcase
        end
    end
endmodule

// File: rtl/idx_bus_seq.sv
module idx_bus_seq
    import idx_seq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    iclass,
    input  logic          prefix,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] x_in,
    input  logic [AW-1:0] sp_in,
    input  logic [2*DW-1:0] reg_data,
    input  logic [DW-1:0] din,
    output logic [AW-1:0] addr,
    output logic          rw,
    output logic [DW-1:0] dout,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_out,
    output logic [AW-1:0] sp_out
);
    seq_st_t st_q, st_d;
    kind_e   kind;
    logic    last;
    logic [AW-1:0] ea;
    cls_e    cls_in;

    assign cls_in = (iclass > 3'd5) ? CL_LOAD : cls_e'(iclass);

    idx_step_decode #(.SW(STEP_W)) u_dec (
        .cls  (st_q.cls),
        .pfx  (st_q.pfx),
        .step (st_q.step),
        .kind (kind),
        .last (last)
    );

    idx_addr_mux #(.AW(AW), .DW(DW)) u_mux (
        .active   (st_q.busy),
        .kind     (kind),
        .cur      (st_q.cur),
        .x        (st_q.x),
        .off      (st_q.off),
        .sp       (st_q.sp),
        .reg_data (reg_data),
        .ea       (ea),
        .addr     (addr),
        .rw       (rw),
        .dout     (dout)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.step = '0;
                st_d.cls  = cls_in;
                st_d.pfx  = prefix;
                st_d.cur  = pc_in;
                st_d.x    = x_in;
                st_d.sp   = sp_in;
                st_d.off  = '0;
            end
        end else begin
            if (kind == K_PROG || kind == K_OFF) st_d.cur = st_q.cur + AW'(1);
            if (kind == K_OFF) st_d.off = din;
            if (last) st_d.busy = 1'b0;
            else      st_d.step = st_q.step + STEP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, step: '0, cls: CL_LOAD, pfx: 1'b0,
                      cur: '0, x: '0, sp: '0, off: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.busy && last;
    assign pc_out = (st_q.cls == CL_CALL) ? ea : st_q.cur;
    assign sp_out = (st_q.cls == CL_CALL) ? st_q.sp - AW'(2) : st_q.sp;

    // R1: the first bus cycle reads the PC captured at start
    p_first_fetch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (addr == $past(pc_in)) && rw);

    // R12: dummy cycles are reads of the all-ones address
    p_dummy_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && kind == K_DUM) |-> (rw && addr == '1));

    // R10: done lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: an active sequence advances one step per cycle whatever start does
    p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy && (st_q.step == $past(st_q.step) + STEP_W'(1)));

    // R11: captured operands hold while busy
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(st_q.x) && $stable(st_q.cls) && $stable(st_q.sp));

    // R8: bit test and branch never writes
    p_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cls == CL_BITBR) |-> rw);

    // R12: no write occurs while idle
    p_idle_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rw);
endmodule

// File: tb/idx_bus_seq_tb.sv
module idx_bus_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  iclass = 3'd0;
    logic        prefix = 1'b0;
    logic [15:0] pc_in = '0, x_in = '0, sp_in = '0, reg_data = '0;
    logic [7:0]  din;
    logic [15:0] addr, pc_out, sp_out;
    logic        rw, busy, done;
    logic [7:0]  dout;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [15:0] a;
        logic        w;
        logic [7:0]  d;
        logic        dn;
        logic [15:0] pc;
        logic [15:0] sp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t tmp[8];
    int    tn;

    logic [15:0] pc_cfg = '0;
    logic        pfx_cfg = 1'b0;
    logic [7:0]  off_cfg = '0;

    always #2 clk = ~clk;

    idx_bus_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .iclass(iclass),
        .prefix(prefix), .pc_in(pc_in), .x_in(x_in), .sp_in(sp_in),
        .reg_data(reg_data), .din(din), .addr(addr), .rw(rw), .dout(dout),
        .busy(busy), .done(done), .pc_out(pc_out), .sp_out(sp_out)
    );

    always_comb begin
        if (addr == pc_cfg + 16'(pfx_cfg) + 16'd1) din = off_cfg;
        else din = addr[7:0] ^ 8'h3C;
    end

    task automatic add(input logic [15:0] a, input logic w, input logic [7:0] d,
                       input string tag);
        tmp[tn] = '{a: a, w: w, d: d, dn: 1'b0, pc: '0, sp: '0, tag: tag};
        tn++;
    endtask

    task automatic run_seq(input int cl, input bit pf, input logic [15:0] pc,
                           input logic [15:0] x, input logic [15:0] sp,
                           input logic [15:0] rd, input logic [7:0] off,
                           input bit glitch);
        logic [15:0] ea, cur;
        string ct;
        ea  = x + {8'h00, off};
        cur = pc;
        tn  = 0;
        case (cl)
            1: ct = "R4";
            2: ct = "R5";
            3: ct = "R6";
            4: ct = "R7";
            5: ct = "R8";
            default: ct = "R3";
        endcase
        add(cur, 1, 0, "R1"); cur++;
        if (pf) begin add(cur, 1, 0, "R2"); cur++; end
        add(cur, 1, 0, "R1"); cur++;
        add(16'hFFFF, 1, 0, "R1");
        case (cl)
            1: begin add(ea, 0, rd[15:8], ct); add(ea + 16'd1, 0, rd[7:0], "R9"); end
            2: begin add(ea, 1, 0, ct); add(ea + 16'd1, 1, 0, ct); add(16'hFFFF, 1, 0, "R12"); end
            3: begin add(ea, 1, 0, ct); add(sp, 0, cur[7:0], ct); add(sp - 16'd1, 0, cur[15:8], ct); end
            4: begin add(ea, 1, 0, ct); add(cur, 1, 0, ct); cur++; add(16'hFFFF, 1, 0, "R12"); add(ea, 0, rd[7:0], ct); end
            5: begin add(ea, 1, 0, ct); add(cur, 1, 0, ct); cur++; add(cur, 1, 0, ct); cur++; add(16'hFFFF, 1, 0, "R12"); end
            default: begin add(ea, 1, 0, ct); add(ea + 16'd1, 1, 0, "R9"); end
        endcase
        tmp[tn-1].dn = 1'b1;
        tmp[tn-1].pc = (cl == 3) ? ea : cur;
        tmp[tn-1].sp = (cl == 3) ? sp - 16'd2 : sp;

        @(negedge clk);
        pc_cfg = pc; pfx_cfg = pf; off_cfg = off;
        for (int i = 0; i < tn; i++) exp_q.push_back(tmp[i]);
        iclass = 3'(cl); prefix = pf; pc_in = pc; x_in = x; sp_in = sp; reg_data = rd;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= tn; i++) begin
            @(negedge clk);
            if (glitch && i == 1) begin
                start = 1'b1; iclass = 3'd1; pc_in = 16'h4444; x_in = 16'h0101;
            end else if (glitch && i == 2) begin
                start = 1'b0;
            end
        end
        #1;
        checks++;
        if (exp_q.size() != 0 || busy) begin
            fails++;
            $display("FAIL R10: sequence length, %0d items left, busy=%0b (expected 0, 0)",
                     exp_q.size(), busy);
            exp_q.delete();
        end
    endtask

    // monitor / scoreboard
    initial begin
        item_t e;
        forever begin
            @(negedge clk);
            if (rst_n && busy) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R11: unexpected bus cycle addr=%h rw=%0b (expected idle)", addr, rw);
                end else begin
                    e = exp_q.pop_front();
                    checks++;
                    if (addr !== e.a || rw !== e.w || done !== e.dn ||
                        (e.w == 1'b0 && dout !== e.d) || (e.w == 1'b1 && dout !== 8'h00)) begin
                        fails++;
                        $display("FAIL %s: addr=%h rw=%0b dout=%h done=%0b (expected %h %0b %h %0b)",
                                 e.tag, addr, rw, dout, done, e.a, e.w, e.w ? 8'h00 : e.d, e.dn);
                    end
                    if (e.dn) begin
                        checks++;
                        if (pc_out !== e.pc || sp_out !== e.sp) begin
                            fails++;
                            $display("FAIL R10: pc_out=%h sp_out=%h (expected %h %h)",
                                     pc_out, sp_out, e.pc, e.sp);
                        end
                    end
                end
            end else if (rst_n) begin
                checks++;
                if (rw !== 1'b1 || done !== 1'b0 || addr !== 16'hFFFF) begin
                    fails++;
                    $display("FAIL R12: idle rw=%0b done=%0b addr=%h (expected 1 0 ffff)", rw, done, addr);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (expected completion)");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || rw !== 1'b1) begin
            fails++;
            $display("FAIL R12: reset busy=%0b done=%0b rw=%0b (expected 0 0 1)", busy, done, rw);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_seq(0, 0, 16'h1000, 16'h2000, 16'h3000, 16'hA55A, 8'h10, 0); // R3
        run_seq(0, 1, 16'h1100, 16'h2000, 16'h3000, 16'hA55A, 8'h22, 0); // R2 R3
        run_seq(1, 0, 16'h1200, 16'h4000, 16'h3000, 16'hBEEF, 8'h05, 0); // R4
        run_seq(1, 1, 16'h1300, 16'h4000, 16'h3000, 16'hC0DE, 8'hFF, 0); // R2 R4
        run_seq(2, 0, 16'h1400, 16'h5000, 16'h3000, 16'h0000, 8'h80, 0); // R5
        run_seq(2, 1, 16'h1500, 16'h5000, 16'h3000, 16'h0000, 8'h81, 0); // R2 R5
        run_seq(3, 0, 16'h16FE, 16'h6000, 16'h01FF, 16'h0000, 8'h33, 0); // R6
        run_seq(4, 0, 16'h1700, 16'h7000, 16'h3000, 16'h00C3, 8'h44, 0); // R7
        run_seq(5, 0, 16'h1800, 16'h7100, 16'h3000, 16'h0000, 8'h55, 0); // R8
        run_seq(5, 1, 16'hFFFD, 16'h7200, 16'h3000, 16'h0000, 8'h66, 0); // R8 R2 pc wrap
        run_seq(0, 0, 16'h1900, 16'hFFF0, 16'h3000, 16'h0000, 8'h0F, 0); // R9
        run_seq(1, 0, 16'h1A00, 16'hFFF0, 16'h3000, 16'h1234, 8'h0F, 0); // R9 store wrap
        run_seq(2, 1, 16'h1B00, 16'h0800, 16'h3000, 16'h0000, 8'h09, 1); // R11
        run_seq(7, 0, 16'h1C00, 16'h0900, 16'h3000, 16'h0000, 8'h01, 0); // R12 code 7 as load
        run_seq(3, 1, 16'h1D00, 16'h0A00, 16'h0000, 16'h0000, 8'h02, 0); // R6 SP wrap

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule